// File: doc/BRIEF.md
# Rotate-Right Read-Modify-Write Unit

This unit executes a rotate-right-through-carry instruction for a CPU core whose accumulator and memory operands can be 8 or 16 bits wide, with the width chosen at run time. A single-cycle `start` hands the unit its operands: the width flag, an addressing-mode code, a 24-bit effective address, the current carry and the accumulator value. The unit then does one of two things. In accumulator mode it rotates the accumulator value in place. In any memory mode it fetches the operand one byte at a time over a byte-wide request/ready bus, rotates it, and stores it back at the same place.

When the work is finished the unit pulses `done`. It returns the rotated value, the new carry, zero and negative flags, the base cycle count of the addressing mode, and the extra cycles the instruction costs. Opcode decode, effective-address generation and the register file belong to the surrounding core.

Top module: `ror_rmw_unit`

## Requirements
- R1: In 8-bit mode (`narrow`=1), result bits [6:0] are operand bits [7:1], result bit 7 is the incoming carry, and the new carry is operand bit 0.
- R2: In 16-bit mode (`narrow`=0), result bits [14:0] are operand bits [15:1], result bit 15 is the incoming carry, and the new carry is operand bit 0.
- R3: The zero flag is 1 exactly when the active-width result (bits [7:0] or [15:0]) is zero.
- R4: The negative flag equals the top bit of the active-width result (bit 7 or bit 15).
- R5: Addressing code 0 is accumulator mode. It makes no bus access, `done` rises in the cycle after `start`, the extra count is 0, and in 8-bit mode result bits [15:8] equal `acc_in[15:8]`.
- R6: A memory operand is read low byte first at `eff_addr`, then (16-bit only) the high byte at `eff_addr`+1 modulo 2^24. It is then written back low byte at `eff_addr`, then (16-bit only) the high byte at `eff_addr`+1. In 8-bit memory mode, result bits [15:8] are zero.
- R7: Only one of `bus_rd` and `bus_wr` is high at a time. A strobe holds its address and write data until `bus_ready` is sampled high, and each sampled ready completes exactly one byte.
- R8: For a memory mode, the extra count is 2 in 16-bit mode and 0 in 8-bit mode, before the mode additions of R9 and R10.
- R9: For codes 1 (direct page) and 3 (direct page indexed), the extra count gains 1 when `dp_low` is nonzero.
- R10: For code 4 (absolute indexed), the extra count gains 1 when `page_cross` is 1.
- R11: `base_cyc` is 2 for code 0, 5 for code 1, 6 for code 2, 6 for code 3 and 7 for code 4. Codes 5 to 7 behave as code 2.
- R12: `done` is a one-cycle pulse in the cycle after the final byte write (or after `start` in accumulator mode). A `start` while `busy` is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation (sampled when idle) |
| narrow | input | 1 | 1 = 8-bit operand, 0 = 16-bit |
| am | input | 3 | Addressing-mode code |
| eff_addr | input | 24 | Effective address of the memory operand |
| carry_in | input | 1 | Carry flag before the instruction |
| acc_in | input | 16 | Accumulator value |
| dp_low | input | 8 | Low byte of the direct-page base register |
| page_cross | input | 1 | Indexed address crossed a page |
| bus_addr | output | 24 | Byte bus address |
| bus_rd | output | 1 | Byte read request |
| bus_wr | output | 1 | Byte write request |
| bus_wdata | output | 8 | Byte write data |
| bus_rdata | input | 8 | Byte read data, valid with ready |
| bus_ready | input | 1 | Completes the current byte transfer |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| acc_upd | output | 1 | With done: result is for the accumulator |
| result | output | 16 | Rotated value |
| carry_out | output | 1 | New carry flag |
| zero_out | output | 1 | New zero flag |
| neg_out | output | 1 | New negative flag |
| base_cyc | output | 4 | Base cycle count of the addressing mode |
| extra_cyc | output | 4 | Extra cycles for width and mode |

## Verification
A sequencer stuck in the wrong state shows at the bus within one cycle: a strobe of the wrong kind, an address that does not step by one, or a missing or extra byte in the transfer log. A wrong latched width or carry changes the written-back bytes and flags, and the bench compares them at the `done` pulse of the same operation. Sweeping every 8-bit operand with both carries, a dense 16-bit set, and every mode/width/penalty combination means a corrupted operand mux or penalty term is seen on the first operation that uses it.

// File: rtl/ror_pkg.sv
package ror_pkg;
  localparam logic [2:0] AM_ACC  = 3'd0;
  localparam logic [2:0] AM_DP   = 3'd1;
  localparam logic [2:0] AM_ABS  = 3'd2;
  localparam logic [2:0] AM_DPX  = 3'd3;
  localparam logic [2:0] AM_ABSX = 3'd4;

  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_RD_LO = 3'd1,
    S_RD_HI = 3'd2,
    S_WR_LO = 3'd3,
    S_WR_HI = 3'd4
  } seq_state_e;
endpackage

// File: rtl/ror_rotate.sv
module ror_rotate #(
  parameter int BYTE_W = 8
) (
  input  logic                  narrow,
  input  logic                  cin,
  input  logic [2*BYTE_W-1:0]   operand,
  input  logic [BYTE_W-1:0]     keep_hi,
  output logic [2*BYTE_W-1:0]   res,
  output logic                  cout,
  output logic                  zero,
  output logic                  neg
);
  localparam int WORD_W = 2 * BYTE_W;

  logic [BYTE_W-1:0] short_res;
  logic [WORD_W-1:0] long_res;

  always_comb begin
    short_res = {cin, operand[BYTE_W-1:1]};
    long_res  = {cin, operand[WORD_W-1:1]};
    cout      = operand[0];
    if (narrow) begin
      res  = {keep_hi, short_res};
      zero = (short_res == '0);
      neg  = short_res[BYTE_W-1];
    end else begin
      res  = long_res;
      zero = (long_res == '0);
      neg  = long_res[WORD_W-1];
    end
  end
endmodule

// File: rtl/ror_penalty.sv
module ror_penalty
  import ror_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int CYC_W  = 4
) (
  input  logic              narrow,
  input  logic [2:0]        am,
  input  logic [BYTE_W-1:0] dp_low,
  input  logic              page_cross,
  output logic [CYC_W-1:0]  base,
  output logic [CYC_W-1:0]  extra
);
  logic dp_mode;

  always_comb begin
    dp_mode = (am == AM_DP) || (am == AM_DPX);
    case (am)
      AM_ACC:  base = CYC_W'(2);
      AM_DP:   base = CYC_W'(5);
      AM_DPX:  base = CYC_W'(6);
      AM_ABSX: base = CYC_W'(7);
      default: base = CYC_W'(6);
    endcase
    extra = '0;
    if (am != AM_ACC) begin
      if (!narrow)                       extra = CYC_W'(2);
      if (dp_mode && (dp_low != '0))     extra = extra + CYC_W'(1);
      if ((am == AM_ABSX) && page_cross) extra = extra + CYC_W'(1);
    end
  end
endmodule

// File: rtl/ror_seq.sv
module ror_seq
  import ror_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int BYTE_W = 8,
  parameter int CYC_W  = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic                narrow,
  input  logic [2:0]          am,
  input  logic [ADDR_W-1:0]   eff_addr,
  input  logic                carry_in,
  input  logic [2*BYTE_W-1:0] acc_in,
  input  logic [CYC_W-1:0]    pen_base,
  input  logic [CYC_W-1:0]    pen_extra,
  // rotate datapath
  output logic                rot_narrow,
  output logic                rot_cin,
  output logic [2*BYTE_W-1:0] rot_op,
  output logic [BYTE_W-1:0]   rot_keep,
  input  logic [2*BYTE_W-1:0] rot_res,
  input  logic                rot_cout,
  input  logic                rot_zero,
  input  logic                rot_neg,
  // byte bus
  output logic [ADDR_W-1:0]   bus_addr,
  output logic                bus_rd,
  output logic                bus_wr,
  output logic [BYTE_W-1:0]   bus_wdata,
  input  logic [BYTE_W-1:0]   bus_rdata,
  input  logic                bus_ready,
  // results
  output logic                busy,
  output logic                done,
  output logic                acc_upd,
  output logic [2*BYTE_W-1:0] result,
  output logic                carry_out,
  output logic                zero_out,
  output logic                neg_out,
  output logic [CYC_W-1:0]    base_cyc,
  output logic [CYC_W-1:0]    extra_cyc
);
  localparam int WORD_W = 2 * BYTE_W;

  seq_state_e        st;
  logic              n_lat;
  logic              c_lat;
  logic [ADDR_W-1:0] a_lat;
  logic [BYTE_W-1:0] op_lo;
  logic [ADDR_W-1:0] a_next;

  assign busy   = (st != S_IDLE);
  assign a_next = a_lat + ADDR_W'(1);

  always_comb begin
    if (st == S_IDLE) begin
      rot_op     = acc_in;
      rot_cin    = carry_in;
      rot_narrow = narrow;
      rot_keep   = acc_in[WORD_W-1:BYTE_W];
    end else begin
      rot_cin    = c_lat;
      rot_narrow = n_lat;
      rot_keep   = '0;
      if (st == S_RD_HI) rot_op = {bus_rdata, op_lo};
      else               rot_op = {{BYTE_W{1'b0}}, bus_rdata};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= S_IDLE;
      n_lat     <= 1'b0;
      c_lat     <= 1'b0;
      a_lat     <= '0;
      op_lo     <= '0;
      bus_addr  <= '0;
      bus_rd    <= 1'b0;
      bus_wr    <= 1'b0;
      bus_wdata <= '0;
      done      <= 1'b0;
      acc_upd   <= 1'b0;
      result    <= '0;
      carry_out <= 1'b0;
      zero_out  <= 1'b0;
      neg_out   <= 1'b0;
      base_cyc  <= '0;
      extra_cyc <= '0;
    end else begin
      done    <= 1'b0;
      acc_upd <= 1'b0;
      case (st)
        S_IDLE: begin
          if (start) begin
            n_lat     <= narrow;
            c_lat     <= carry_in;
            base_cyc  <= pen_base;
            extra_cyc <= pen_extra;
            if (am == AM_ACC) begin
              result    <= rot_res;
              carry_out <= rot_cout;
              zero_out  <= rot_zero;
              neg_out   <= rot_neg;
              done      <= 1'b1;
              acc_upd   <= 1'b1;
            end else begin
              a_lat    <= eff_addr;
              bus_addr <= eff_addr;
              bus_rd   <= 1'b1;
              st       <= S_RD_LO;
            end
          end
        end
        S_RD_LO: begin
          if (bus_ready) begin
            if (n_lat) begin
              bus_rd    <= 1'b0;
              result    <= rot_res;
              carry_out <= rot_cout;
              zero_out  <= rot_zero;
              neg_out   <= rot_neg;
              bus_wr    <= 1'b1;
              bus_wdata <= rot_res[BYTE_W-1:0];
              bus_addr  <= a_lat;
              st        <= S_WR_LO;
            end else begin
              op_lo    <= bus_rdata;
              bus_addr <= a_next;
              st       <= S_RD_HI;
            end
          end
        end
        S_RD_HI: begin
          if (bus_ready) begin
            bus_rd    <= 1'b0;
            result    <= rot_res;
            carry_out <= rot_cout;
            zero_out  <= rot_zero;
            neg_out   <= rot_neg;
            bus_wr    <= 1'b1;
            bus_wdata <= rot_res[BYTE_W-1:0];
            bus_addr  <= a_lat;
            st        <= S_WR_LO;
          end
        end
        S_WR_LO: begin
          if (bus_ready) begin
            if (n_lat) begin
              bus_wr <= 1'b0;
              done   <= 1'b1;
              st     <= S_IDLE;
            end else begin
              bus_wdata <= result[WORD_W-1:BYTE_W];
              bus_addr  <= a_next;
              st        <= S_WR_HI;
            end
          end
        end
        S_WR_HI: begin
          if (bus_ready) begin
            bus_wr <= 1'b0;
            done   <= 1'b1;
            st     <= S_IDLE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ror_rmw_unit.sv
module ror_rmw_unit #(
  parameter int ADDR_W = 24,
  parameter int BYTE_W = 8,
  parameter int CYC_W  = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic                narrow,
  input  logic [2:0]          am,
  input  logic [ADDR_W-1:0]   eff_addr,
  input  logic                carry_in,
  input  logic [2*BYTE_W-1:0] acc_in,
  input  logic [BYTE_W-1:0]   dp_low,
  input  logic                page_cross,
  output logic [ADDR_W-1:0]   bus_addr,
  output logic                bus_rd,
  output logic                bus_wr,
  output logic [BYTE_W-1:0]   bus_wdata,
  input  logic [BYTE_W-1:0]   bus_rdata,
  input  logic                bus_ready,
  output logic                busy,
  output logic                done,
  output logic                acc_upd,
  output logic [2*BYTE_W-1:0] result,
  output logic                carry_out,
  output logic                zero_out,
  output logic                neg_out,
  output logic [CYC_W-1:0]    base_cyc,
  output logic [CYC_W-1:0]    extra_cyc
);
  localparam int WORD_W = 2 * BYTE_W;

  logic              rot_narrow;
  logic              rot_cin;
  logic [WORD_W-1:0] rot_op;
  logic [BYTE_W-1:0] rot_keep;
  logic [WORD_W-1:0] rot_res;
  logic              rot_cout;
  logic              rot_zero;
  logic              rot_neg;
  logic [CYC_W-1:0]  pen_base;
  logic [CYC_W-1:0]  pen_extra;

  ror_rotate #(.BYTE_W(BYTE_W)) u_rot (
    .narrow  (rot_narrow),
    .cin     (rot_cin),
    .operand (rot_op),
    .keep_hi (rot_keep),
    .res     (rot_res),
    .cout    (rot_cout),
    .zero    (rot_zero),
    .neg     (rot_neg)
  );

  ror_penalty #(.BYTE_W(BYTE_W), .CYC_W(CYC_W)) u_pen (
    .narrow     (narrow),
    .am         (am),
    .dp_low     (dp_low),
    .page_cross (page_cross),
    .base       (pen_base),
    .extra      (pen_extra)
  );

  ror_seq #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .CYC_W(CYC_W)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .narrow     (narrow),
    .am         (am),
    .eff_addr   (eff_addr),
    .carry_in   (carry_in),
    .acc_in     (acc_in),
    .pen_base   (pen_base),
    .pen_extra  (pen_extra),
    .rot_narrow (rot_narrow),
    .rot_cin    (rot_cin),
    .rot_op     (rot_op),
    .rot_keep   (rot_keep),
    .rot_res    (rot_res),
    .rot_cout   (rot_cout),
    .rot_zero   (rot_zero),
    .rot_neg    (rot_neg),
    .bus_addr   (bus_addr),
    .bus_rd     (bus_rd),
    .bus_wr     (bus_wr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .bus_ready  (bus_ready),
    .busy       (busy),
    .done       (done),
    .acc_upd    (acc_upd),
    .result     (result),
    .carry_out  (carry_out),
    .zero_out   (zero_out),
    .neg_out    (neg_out),
    .base_cyc   (base_cyc),
    .extra_cyc  (extra_cyc)
  );
endmodule

// File: rtl/ror_rmw_unit_chk.sv
module ror_rmw_unit_chk #(
  parameter int ADDR_W = 24,
  parameter int BYTE_W = 8,
  parameter int CYC_W  = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic [2:0]        am,
  input logic              busy,
  input logic              done,
  input logic              bus_rd,
  input logic              bus_wr,
  input logic              bus_ready,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [BYTE_W-1:0] bus_wdata,
  input logic [CYC_W-1:0]  extra_cyc
);
  a_r7_one_strobe: assert property (@(posedge clk) disable iff (rst)
    !(bus_rd && bus_wr));

  a_r7_rd_hold: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && !bus_ready) |=> (bus_rd && $stable(bus_addr)));

  a_r7_wr_hold: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && !bus_ready) |=> (bus_wr && $stable(bus_addr) && $stable(bus_wdata)));

  a_r5_acc_no_bus: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && am == 3'd0) |=> (done && !bus_rd && !bus_wr));

  a_r12_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r12_done_idle: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && !bus_rd && !bus_wr));

  a_r8_extra_range: assert property (@(posedge clk) disable iff (rst)
    done |-> (extra_cyc <= CYC_W'(3)));
endmodule

bind ror_rmw_unit ror_rmw_unit_chk #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .CYC_W(CYC_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .start     (start),
  .am        (am),
  .busy      (busy),
  .done      (done),
  .bus_rd    (bus_rd),
  .bus_wr    (bus_wr),
  .bus_ready (bus_ready),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .extra_cyc (extra_cyc)
);

// File: tb/ror_rmw_unit_test.sv
module ror_rmw_unit_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        narrow = 1'b1;
  logic [2:0]  am = 3'd0;
  logic [23:0] eff_addr = '0;
  logic        carry_in = 1'b0;
  logic [15:0] acc_in = '0;
  logic [7:0]  dp_low = '0;
  logic        page_cross = 1'b0;
  logic [23:0] bus_addr;
  logic        bus_rd, bus_wr;
  logic [7:0]  bus_wdata;
  logic [7:0]  bus_rdata = '0;
  logic        bus_ready = 1'b0;
  logic        busy, done, acc_upd, carry_out, zero_out, neg_out;
  logic [15:0] result;
  logic [3:0]  base_cyc, extra_cyc;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  int done_cnt = 0;
  int lat = 0;
  int wcnt = 0;
  int log_n = 0;
  logic [24:0] log_e [0:7];
  logic [7:0]  mem [0:255];

  always #5 clk = ~clk;

  ror_rmw_unit uut (.*);

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (done) done_cnt <= done_cnt + 1;
  end

  // byte bus responder with programmable wait states
  always @(negedge clk) begin
    if (rst) begin
      bus_ready = 1'b0;
      wcnt = 0;
    end else if (bus_ready) begin
      bus_ready = 1'b0;
      wcnt = 0;
    end else if (bus_rd || bus_wr) begin
      if (wcnt >= lat) begin
        bus_ready = 1'b1;
        if (bus_rd) bus_rdata = mem[bus_addr[7:0]];
        else        mem[bus_addr[7:0]] = bus_wdata;
        if (log_n < 8) log_e[log_n] = {bus_wr, bus_addr};
        log_n++;
      end else begin
        wcnt++;
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_op(input logic n, input logic [2:0] m, input logic [23:0] a,
                        input logic c, input logic [15:0] acc, input logic [7:0] dpl,
                        input logic pc, input int l);
    int k;
    @(negedge clk);
    narrow = n; am = m; eff_addr = a; carry_in = c; acc_in = acc;
    dp_low = dpl; page_cross = pc; lat = l; log_n = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    k = 0;
    while (!done && k < 60) begin
      @(negedge clk);
      k++;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R12 done missing actual=0 expected=1");
    end
  endtask

  initial begin : wdog
    wait (cycles > 150000);
    errors++;
    $display("FAIL watchdog actual=%0d expected<150000", cycles);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = '0;
    for (int i = 0; i < 8; i++) log_e[i] = '0;
    repeat (3) @(negedge clk);
    // reset state
    chk("R12 reset busy", busy, 0);
    chk("R12 reset done", done, 0);
    chk("R7 reset strobes", {bus_rd, bus_wr}, 0);
    rst = 1'b0;
    @(negedge clk);

    // R1 R3 R4 R6: all 8-bit memory operands, both carries
    for (int c = 0; c < 2; c++) begin
      for (int v = 0; v < 256; v++) begin
        logic [7:0] e8;
        e8 = {c[0], v[7:1]};
        mem[8'h10] = v[7:0];
        run_op(1'b1, 3'd2, 24'h123410, c[0], 16'hFFFF, 8'h00, 1'b0, v % 3);
        chk("R1 mem8 result", result, {8'h00, e8});
        chk("R1 mem8 carry", carry_out, v[0]);
        chk("R3 mem8 zero", zero_out, (e8 == 0));
        chk("R4 mem8 neg", neg_out, e8[7]);
        chk("R6 mem8 written", mem[8'h10], e8);
        chk("R6 mem8 count", log_n, 2);
        chk("R6 mem8 rd", log_e[0], {1'b0, 24'h123410});
        chk("R6 mem8 wr", log_e[1], {1'b1, 24'h123410});
        chk("R5 mem8 acc_upd", acc_upd, 0);
      end
    end

    // R2 R3 R4 R6: dense 16-bit memory set
    for (int i = 0; i < 260; i++) begin
      logic [15:0] v, e16;
      logic ci;
      v = (i == 0) ? 16'h0000 : (i == 1) ? 16'h0001 : (i == 2) ? 16'h83B3 : 16'(i * 40503);
      ci = (i == 2) ? 1'b1 : i[0];
      e16 = {ci, v[15:1]};
      mem[8'h20] = v[7:0];
      mem[8'h21] = v[15:8];
      run_op(1'b0, 3'd2, 24'hAB0020, ci, 16'h0000, 8'h00, 1'b0, i % 2);
      chk("R2 mem16 result", result, e16);
      chk("R2 mem16 carry", carry_out, v[0]);
      chk("R3 mem16 zero", zero_out, (e16 == 0));
      chk("R4 mem16 neg", neg_out, e16[15]);
      chk("R6 mem16 lo", mem[8'h20], e16[7:0]);
      chk("R6 mem16 hi", mem[8'h21], e16[15:8]);
      chk("R6 mem16 count", log_n, 4);
      chk("R6 mem16 order0", log_e[0], {1'b0, 24'hAB0020});
      chk("R6 mem16 order1", log_e[1], {1'b0, 24'hAB0021});
      chk("R6 mem16 order2", log_e[2], {1'b1, 24'hAB0020});
      chk("R6 mem16 order3", log_e[3], {1'b1, 24'hAB0021});
    end

    // R5: accumulator mode, 8-bit, upper byte preserved
    for (int c = 0; c < 2; c++) begin
      for (int v = 0; v < 256; v++) begin
        logic [7:0] e8, hi;
        hi = ~v[7:0];
        e8 = {c[0], v[7:1]};
        run_op(1'b1, 3'd0, 24'h000000, c[0], {hi, v[7:0]}, 8'h55, 1'b1, 0);
        chk("R5 acc8 result", result, {hi, e8});
        chk("R1 acc8 carry", carry_out, v[0]);
        chk("R3 acc8 zero", zero_out, (e8 == 0));
        chk("R5 acc8 no bus", log_n, 0);
        chk("R5 acc8 extra", extra_cyc, 0);
        chk("R5 acc8 acc_upd", acc_upd, 1);
      end
    end

    // R2 R5: accumulator mode, 16-bit
    run_op(1'b0, 3'd0, 24'h0, 1'b1, 16'h83B3, 8'h00, 1'b0, 0);
    chk("R2 acc16 result", result, 16'hC1D9);
    chk("R2 acc16 carry", carry_out, 1);
    chk("R5 acc16 extra", extra_cyc, 0);
    run_op(1'b0, 3'd0, 24'h0, 1'b0, 16'h0001, 8'h00, 1'b0, 0);
    chk("R3 acc16 zero", zero_out, 1);
    chk("R4 acc16 neg", neg_out, 0);
    chk("R5 acc16 no bus", log_n, 0);

    // R8 R9 R10 R11: every mode, width and penalty condition
    for (int m = 0; m < 8; m++) begin
      for (int n = 0; n < 2; n++) begin
        for (int d = 0; d < 2; d++) begin
          for (int p = 0; p < 2; p++) begin
            int eb, ee;
            case (m)
              0: eb = 2;
              1: eb = 5;
              3: eb = 6;
              4: eb = 7;
              default: eb = 6;
            endcase
            ee = 0;
            if (m != 0) begin
              if (n == 0) ee = 2;
              if ((m == 1 || m == 3) && d == 1) ee++;
              if (m == 4 && p == 1) ee++;
            end
            run_op(n[0], m[2:0], 24'h000040, 1'b0, 16'h1234, (d == 1) ? 8'h80 : 8'h00, p[0], 0);
            chk("R11 base cycles", base_cyc, eb);
            chk("R8 R9 R10 extra cycles", extra_cyc, ee);
          end
        end
      end
    end

    // R6: address wrap for the high byte
    mem[8'hFF] = 8'h02;
    mem[8'h00] = 8'h80;
    run_op(1'b0, 3'd4, 24'hFFFFFF, 1'b0, 16'h0, 8'h00, 1'b0, 1);
    chk("R6 wrap order1", log_e[1], {1'b0, 24'h000000});
    chk("R6 wrap order3", log_e[3], {1'b1, 24'h000000});
    chk("R2 wrap result", result, 16'h4001);
    chk("R6 wrap hi", mem[8'h00], 8'h40);

    // R12: start while busy is ignored; exactly one done pulse
    mem[8'h30] = 8'h34;
    mem[8'h31] = 8'h12;
    @(negedge clk);
    begin
      int d0, k;
      d0 = done_cnt;
      narrow = 1'b0; am = 3'd1; eff_addr = 24'h000030; carry_in = 1'b0;
      acc_in = 16'hFFFF; lat = 2; log_n = 0;
      start = 1'b1;
      @(negedge clk);
      narrow = 1'b1; am = 3'd0; carry_in = 1'b1;
      @(negedge clk);
      @(negedge clk);
      start = 1'b0;
      k = 0;
      while (!done && k < 60) begin
        @(negedge clk);
        k++;
      end
      chk("R12 busy start result", result, 16'h091A);
      chk("R12 busy start bytes", log_n, 4);
      chk("R12 busy start acc_upd", acc_upd, 0);
      @(negedge clk);
      chk("R12 done one cycle", done, 0);
      repeat (5) @(negedge clk);
      chk("R12 single done", done_cnt - d0, 1);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule